// File: doc/BRIEF.md
# Radio Operating Mode Controller

This block chooses how a half-duplex radio is configured. There are two ways to configure it. After reset it runs stand-alone: strap pins select one of four fixed channels, and two state pins select standby, receive, transmit or idle. When the shared channel/enable pin changes level for the first time, the block moves into register mode and never returns. In register mode, four decoded 22-bit configuration words provide the state, the divider ratios, the modulation and the power settings.

From the selected state the block drives three outputs: the reference divide ratio, the feedback divide ratio (receive or transmit ratios, as the state requires) and the enables for the synthesizer, the receive chain and the power amplifier. In register mode the second strap pin becomes an output that carries the lock indication. All pin inputs pass through a two-flop synchronizer.

Top module: `radio_mode_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the block is in fixed mode. The state reads standby (00), all enables are low, both dividers read 0 and the channel pin is not driven.
- R2: The fixed channel is latched from {pin_ch1, pin_ch0} when reset ends. Later level changes on pin_ch1 do not alter the divider outputs in fixed mode.
- R3: Fixed-mode reference and receive feedback ratios, by channel code: 00 gives 16/1919, 01 gives 16/947, 10 gives 30/3794, 11 gives 18/766. These ratios are also used in idle.
- R4: Fixed-mode transmit feedback ratios, by channel code: 00 gives 1943, 01 gives 971, 10 gives 3839, 11 gives 793. The reference ratio is the same as in receive.
- R5: In fixed mode the state is {pin_tx, pin_rx}, reported on state_o. 00 is standby with no enables. 01 is receive, with synth and rx enabled. 10 is transmit, with synth and tx enabled. 11 is idle, with only synth enabled.
- R6: The first level change on pin_ch0 after reset moves the block into register mode, and it stays there. From then on chan1_oe_o is 1 and chan1_drv_o follows lock_i.
- R7: In register mode the state is taken from cfg_a[11:10], where bit 11 is transmit and bit 10 is receive. The encoding is the same as R5. While cfg_valid_i is 0 the state is standby. The state pins have no effect in this mode.
- R8: In register mode the reference ratio is cfg_a[9:0] for receive/idle and cfg_b[9:0] for transmit. The feedback ratio is cfg_c[16:0] for receive/idle and cfg_d[16:0] for transmit.
- R9: mod_fsk_o is 1 for FSK and 0 for ASK. Its source is pin_mod in fixed mode and cfg_a[18] in register mode.
- R10: data_inv_o equals cfg_a[19] in register mode and 0 in fixed mode. pa_level_o equals cfg_a[15:14] in register mode and 11 (full power) in fixed mode. The codes 00/01/10 mean 20/12/6 dB below full power.
- R11: On entry to standby, and for as long as it lasts, both divider outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_ch0 | input | 1 | Channel strap bit 0 / serial enable level |
| pin_ch1 | input | 1 | Channel strap bit 1 |
| pin_rx | input | 1 | Fixed-mode receive state pin |
| pin_tx | input | 1 | Fixed-mode transmit state pin |
| pin_mod | input | 1 | Fixed-mode modulation select |
| lock_i | input | 1 | Lock indication to place on the channel pin |
| cfg_valid_i | input | 1 | Configuration words have been written |
| cfg_a | input | 22 | Word: RX reference, state, power, modulation, data sense |
| cfg_b | input | 22 | Word: TX reference |
| cfg_c | input | 22 | Word: RX feedback |
| cfg_d | input | 22 | Word: TX feedback |
| prog_mode_o | output | 1 | Register mode active |
| state_o | output | 2 | Current state {tx,rx} |
| ref_div_o | output | 10 | Active reference divide ratio |
| fb_div_o | output | 17 | Active feedback divide ratio |
| mod_fsk_o | output | 1 | 1 = FSK, 0 = ASK |
| data_inv_o | output | 1 | Transmit data sense inverted |
| pa_level_o | output | 2 | Output power code |
| en_synth_o | output | 1 | Synthesizer enable |
| en_rx_o | output | 1 | Receive chain enable |
| en_tx_o | output | 1 | Power amplifier enable |
| chan1_oe_o | output | 1 | Drive enable for the channel-1 pin |
| chan1_drv_o | output | 1 | Value driven on the channel-1 pin |

## Verification
A wrong channel latch shows up as a wrong divider pair three cycles after the first state pin change, and it stays wrong until the next reset. A mode flag that is lost or set too early shows up through the state pins: in register mode they stop having any effect, and chan1_oe_o drops. Both are visible about four cycles after the pin_ch0 edge. If the standby hold is broken, the dividers change during standby in the same cycle the state changes, which can be seen in the standby dwell that follows each scenario.

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl #(
  parameter int REF_W  = 10,
  parameter int FB_W   = 17,
  parameter int WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_ch0,
  input  logic              pin_ch1,
  input  logic              pin_rx,
  input  logic              pin_tx,
  input  logic              pin_mod,
  input  logic              lock_i,
  input  logic              cfg_valid_i,
  input  logic [WORD_W-1:0] cfg_a,
  input  logic [WORD_W-1:0] cfg_b,
  input  logic [WORD_W-1:0] cfg_c,
  input  logic [WORD_W-1:0] cfg_d,
  output logic              prog_mode_o,
  output logic [1:0]        state_o,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [FB_W-1:0]   fb_div_o,
  output logic              mod_fsk_o,
  output logic              data_inv_o,
  output logic [1:0]        pa_level_o,
  output logic              en_synth_o,
  output logic              en_rx_o,
  output logic              en_tx_o,
  output logic              chan1_oe_o,
  output logic              chan1_drv_o
);
  localparam int NPIN = 5;
  localparam logic [1:0] ST_STBY = 2'b00;
  localparam logic [1:0] ST_TX   = 2'b10;

  logic [NPIN-1:0] sync1, sync2;
  logic ch0_s, ch1_s, rx_s, tx_s, mod_s;

  always_ff @(posedge clk) begin
    sync1 <= {pin_mod, pin_tx, pin_rx, pin_ch1, pin_ch0};
    sync2 <= sync1;
  end
  assign {mod_s, tx_s, rx_s, ch1_s, ch0_s} = sync2;

  logic       started, ch0_ref;
  logic [1:0] chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started     <= 1'b0;
      ch0_ref     <= 1'b0;
      chan        <= 2'b00;
      prog_mode_o <= 1'b0;
    end else if (!started) begin
      started <= 1'b1;
      ch0_ref <= ch0_s;
      chan    <= {ch1_s, ch0_s};
    end else if (ch0_s != ch0_ref) begin
      prog_mode_o <= 1'b1;
    end
  end

  logic [REF_W-1:0] fix_ref;
  logic [FB_W-1:0]  fix_fb_rx, fix_fb_tx;

  always_comb begin
    case (chan)
      2'b00:   begin fix_ref = REF_W'(16); fix_fb_rx = FB_W'(1919); fix_fb_tx = FB_W'(1943); end
      2'b01:   begin fix_ref = REF_W'(16); fix_fb_rx = FB_W'(947);  fix_fb_tx = FB_W'(971);  end
      2'b10:   begin fix_ref = REF_W'(30); fix_fb_rx = FB_W'(3794); fix_fb_tx = FB_W'(3839); end
      default: begin fix_ref = REF_W'(18); fix_fb_rx = FB_W'(766);  fix_fb_tx = FB_W'(793);  end
    endcase
  end

  logic [1:0] nst;
  logic       n_tx;
  logic [REF_W-1:0] n_ref;
  logic [FB_W-1:0]  n_fb;

  assign nst = !started    ? ST_STBY :
               prog_mode_o ? (cfg_valid_i ? cfg_a[11:10] : ST_STBY) :
                             {tx_s, rx_s};
  assign n_tx  = (nst == ST_TX);
  assign n_ref = prog_mode_o ? (n_tx ? cfg_b[REF_W-1:0] : cfg_a[REF_W-1:0]) : fix_ref;
  assign n_fb  = prog_mode_o ? (n_tx ? cfg_d[FB_W-1:0]  : cfg_c[FB_W-1:0])  :
                               (n_tx ? fix_fb_tx : fix_fb_rx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o    <= ST_STBY;
      ref_div_o  <= '0;
      fb_div_o   <= '0;
      mod_fsk_o  <= 1'b0;
      data_inv_o <= 1'b0;
      pa_level_o <= 2'b00;
      en_synth_o <= 1'b0;
      en_rx_o    <= 1'b0;
      en_tx_o    <= 1'b0;
    end else begin
      state_o    <= nst;
      en_synth_o <= (nst != ST_STBY);
      en_rx_o    <= (nst == 2'b01);
      en_tx_o    <= n_tx;
      mod_fsk_o  <= prog_mode_o ? cfg_a[18] : mod_s;
      data_inv_o <= prog_mode_o & cfg_a[19];
      pa_level_o <= prog_mode_o ? cfg_a[15:14] : 2'b11;
      if (nst != ST_STBY) begin
        ref_div_o <= n_ref;
        fb_div_o  <= n_fb;
      end
    end
  end

  assign chan1_oe_o  = prog_mode_o;
  assign chan1_drv_o = prog_mode_o & lock_i;

  // R6
  prog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode_o |=> prog_mode_o);

  // R5
  rx_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_rx_o, en_tx_o}));

  // R11
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_STBY) |-> ($stable(ref_div_o) && $stable(fb_div_o)));

  // R5
  synth_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rx_o || en_tx_o) |-> en_synth_o);

  // R7
  unprog_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode_o && $past(prog_mode_o) && !$past(cfg_valid_i)) |-> (state_o == ST_STBY));
endmodule

// File: tb/test_radio_mode_ctrl.sv
module test_radio_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_ch0 = 0, pin_ch1 = 0, pin_rx = 0, pin_tx = 0, pin_mod = 0, lock_i = 0, cfg_valid_i = 0;
  logic [21:0] cfg_a = '0, cfg_b = '0, cfg_c = '0, cfg_d = '0;
  logic prog_mode_o, mod_fsk_o, data_inv_o, en_synth_o, en_rx_o, en_tx_o, chan1_oe_o, chan1_drv_o;
  logic [1:0] state_o, pa_level_o;
  logic [9:0] ref_div_o;
  logic [16:0] fb_div_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_mode_ctrl i_radio_mode_ctrl (
    .clk, .rst_n, .pin_ch0, .pin_ch1, .pin_rx, .pin_tx, .pin_mod, .lock_i, .cfg_valid_i,
    .cfg_a, .cfg_b, .cfg_c, .cfg_d, .prog_mode_o, .state_o, .ref_div_o, .fb_div_o,
    .mod_fsk_o, .data_inv_o, .pa_level_o, .en_synth_o, .en_rx_o, .en_tx_o,
    .chan1_oe_o, .chan1_drv_o);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] code);
    rst_n = 0; pin_ch0 = code[0]; pin_ch1 = code[1];
    pin_rx = 0; pin_tx = 0; cfg_valid_i = 0;
    step(4);
    chk("R1 prog", prog_mode_o, 0);
    chk("R1 state", state_o, 0);
    chk("R1 enables", {en_synth_o, en_rx_o, en_tx_o}, 0);
    chk("R1 ref", ref_div_o, 0);
    chk("R1 fb", fb_div_o, 0);
    chk("R1 pin oe", chan1_oe_o, 0);
    rst_n = 1;
    step(1);
    chk("R1 state after release", state_o, 0);
  endtask

  task automatic test_fixed(input logic [1:0] code, input int rf, input int fbr, input int fbt);
    do_reset(code);
    pin_rx = 1; pin_tx = 0; step(5);
    chk("R3 ref rx", ref_div_o, rf);
    chk("R3 fb rx", fb_div_o, fbr);
    chk("R5 rx state", state_o, 1);
    chk("R5 rx enables", {en_synth_o, en_rx_o, en_tx_o}, 3'b110);
    pin_rx = 0; pin_tx = 1; step(5);
    chk("R4 ref tx", ref_div_o, rf);
    chk("R4 fb tx", fb_div_o, fbt);
    chk("R5 tx enables", {en_synth_o, en_rx_o, en_tx_o}, 3'b101);
    pin_ch1 = ~code[1]; step(5);
    chk("R2 fb after ch1 change", fb_div_o, fbt);
    chk("R2 still fixed", prog_mode_o, 0);
    pin_ch1 = code[1];
    pin_rx = 1; pin_tx = 1; step(5);
    chk("R3 idle fb", fb_div_o, fbr);
    chk("R5 idle enables", {en_synth_o, en_rx_o, en_tx_o}, 3'b100);
    pin_rx = 0; pin_tx = 0; step(5);
    chk("R11 standby ref", ref_div_o, rf);
    chk("R11 standby fb", fb_div_o, fbr);
    chk("R5 standby enables", {en_synth_o, en_rx_o, en_tx_o}, 0);
  endtask

  task automatic test_fixed_misc();
    do_reset(2'b01);
    pin_mod = 1; pin_rx = 1; step(5);
    chk("R9 fixed fsk", mod_fsk_o, 1);
    pin_mod = 0; step(5);
    chk("R9 fixed ask", mod_fsk_o, 0);
    cfg_a = 22'h3FFFFF; step(2);
    chk("R10 fixed inv", data_inv_o, 0);
    chk("R10 fixed power", pa_level_o, 3);
    cfg_a = '0;
  endtask

  task automatic test_prog();
    do_reset(2'b00);
    pin_rx = 1; step(5);
    chk("R3 pre-prog rx fb", fb_div_o, 1919);
    cfg_valid_i = 0;
    pin_ch0 = 1; step(6);
    chk("R6 prog entered", prog_mode_o, 1);
    chk("R6 pin oe", chan1_oe_o, 1);
    lock_i = 1; #1;
    chk("R6 lock drive", chan1_drv_o, 1);
    lock_i = 0; #1;
    chk("R6 lock drive low", chan1_drv_o, 0);
    chk("R7 unconfigured standby", state_o, 0);
    chk("R11 held fb", fb_div_o, 1919);
    cfg_a = '0;
    cfg_a[9:0] = 10'd77; cfg_a[11:10] = 2'b01; cfg_a[15:14] = 2'b10;
    cfg_a[18] = 1'b1; cfg_a[19] = 1'b1;
    cfg_b = 22'd301; cfg_c = 22'd65000; cfg_d = 22'd100001;
    cfg_valid_i = 1; step(2);
    chk("R7 reg rx state", state_o, 1);
    chk("R8 reg rx ref", ref_div_o, 77);
    chk("R8 reg rx fb", fb_div_o, 65000);
    chk("R9 reg fsk", mod_fsk_o, 1);
    chk("R10 reg inv", data_inv_o, 1);
    chk("R10 reg power", pa_level_o, 2);
    cfg_a[11:10] = 2'b10; cfg_a[18] = 0; cfg_a[19] = 0; step(2);
    chk("R7 reg tx state", state_o, 2);
    chk("R8 reg tx ref", ref_div_o, 301);
    chk("R8 reg tx fb", fb_div_o, 100001);
    chk("R9 reg ask", mod_fsk_o, 0);
    chk("R10 reg no inv", data_inv_o, 0);
    pin_rx = 1; pin_tx = 1; pin_ch0 = 0; step(6);
    chk("R6 sticky", prog_mode_o, 1);
    chk("R7 pins ignored", state_o, 2);
    cfg_a[11:10] = 2'b11; step(2);
    chk("R8 idle uses rx fb", fb_div_o, 65000);
    chk("R7 idle enables", {en_synth_o, en_rx_o, en_tx_o}, 3'b100);
    cfg_a[11:10] = 2'b00; cfg_c = 22'd5; step(2);
    chk("R11 reg standby fb", fb_div_o, 65000);
    chk("R7 reg standby", state_o, 0);
  endtask

  initial begin
    fork
      begin
        test_fixed(2'b00, 16, 1919, 1943);
        test_fixed(2'b01, 16, 947, 971);
        test_fixed(2'b10, 30, 3794, 3839);
        test_fixed(2'b11, 18, 766, 793);
        test_fixed_misc();
        test_prog();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule